// File: doc/BRIEF.md
# Programmable Sink-Current Port Controller

This block is the digital side of an eight-pin port whose pins either float high on a pull-up or pull low through an adjustable current sink. A single level bit per pin chooses the mode. A one turns on the pull-up and turns the sink off, so the pin can be driven high or read as an input. A zero turns the pull-up off and turns the sink on. The sink then runs at a 4-bit strength held for that pin. The controller drives per-pin pull-up enables, sink enables and strength codes toward an external analog driver. The current sources and pads are not part of this block.

The same pins can be watched for edges. Each pin input passes through a two-flop synchronizer before edge detection. Every pin has its own edge sense, rising or falling. A matching edge sets a sticky per-pin flag. The flag stays set until software writes a one to it. A per-pin enable decides whether that flag reaches the single port interrupt line.

On the default build, pins 0 and 1 feed the high-current sinks and pins 2 to 7 feed the lower-current sinks. All eight pins use the same 4-bit code. A flat register bus gives access to every register: an address, write data, a write strobe, and read data that follows the address combinationally.

Top module: `sink_port_ctrl`

## Requirements
- R1: After reset, the level register is all ones. So `pullup_en` is all ones, `sink_en` is all zeros, every strength code is 0, the enable and edge-sense registers are 0, every pending flag is 0 and `irq` is 0.
- R2: The level register is at address 0. A level bit of 1 gives pull-up on and sink off for that pin. A bit of 0 gives pull-up off and sink on. The outputs take the written value on the cycle after the write.
- R3: The strength code of pin i is at address 8+i and takes write-data bits [3:0]. Higher write-data bits are ignored. `strength[4i+3:4i]` always shows pin i's code, whatever the pin's level bit.
- R4: Address 1 is read-only. It returns the pin inputs after a two-flop synchronizer, so a change at the input becomes readable two clock edges later.
- R5: The edge-sense register is at address 3. A bit of 0 selects rising edges (0 to 1) and a bit of 1 selects falling edges (1 to 0). Only a synchronized edge of the selected direction sets that pin's pending flag. An edge in the other direction does not.
- R6: The pending flags are at address 4. They are sticky. Writing 1 to a bit clears it and writing 0 has no effect. When a clear and a new qualifying edge fall on the same cycle, the flag stays set.
- R7: The enable register is at address 2. `irq` is high exactly when some pin has both its pending flag and its enable bit set. A disabled pin still records its pending flag.
- R8: Addresses 0, 2, 3 and 4 read back what they hold. Addresses 5, 6, 7 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| we | input | 1 | Write strobe, one write per cycle |
| rdata | output | 8 | Read data for `addr` (combinational) |
| pin_in | input | 8 | Pin input levels (asynchronous) |
| pullup_en | output | 8 | Per-pin pull-up enable |
| sink_en | output | 8 | Per-pin current-sink enable |
| strength | output | 32 | Per-pin 4-bit sink strength, pin i at [4i+3:4i] |
| irq | output | 1 | Combined port interrupt request |

## Verification
The bench builds the block with its default parameters: eight pins, 4-bit codes, an 8-bit data bus and a 4-bit address. With that build, every strength address from 8 to 15 can be written, and so can the unmapped addresses 5 to 7. The full 8-bit level and edge-sense patterns let one stimulus split the pins into rising-sensitive and falling-sensitive halves. The pin-input timing is placed so that a software clear and a fresh qualifying edge land on the same clock edge, which shows that the flag stays set.

// File: rtl/sink_port_pkg.sv
package sink_port_pkg;

    localparam int unsigned SP_PINS   = 8;
    localparam int unsigned SP_CODE_W = 4;
    localparam int unsigned SP_DATA_W = 8;
    localparam int unsigned SP_ADDR_W = 4;

    // Register selects on the flat bus.
    typedef enum logic [7:0] {
        REG_LEVEL = 8'd0,
        REG_PINS  = 8'd1,
        REG_MASK  = 8'd2,
        REG_SENSE = 8'd3,
        REG_PEND  = 8'd4,
        REG_CODE0 = 8'd8
    } sp_reg_e;

    // Qualifying edge for one pin: sense 0 = rising, 1 = falling.
    function automatic logic sp_edge_hit(input logic sense, input logic now_lvl,
                                         input logic was_lvl);
        return sense ? (was_lvl && !now_lvl) : (now_lvl && !was_lvl);
    endfunction

endpackage

// File: rtl/sink_port_sync.sv
module sink_port_sync #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] meta_q;

    // Reset to the pulled-up level so no edge appears when reset ends.
    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q   <= '1;
            sync_out <= '1;
        end else begin
            meta_q   <= raw_in;
            sync_out <= meta_q;
        end
    end
endmodule

// File: rtl/sink_port_edge.sv
module sink_port_edge (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic sense,
    input  logic clr,
    output logic pend
);
    import sink_port_pkg::*;

    logic lvl_prev;
    logic hit;

    assign hit = sp_edge_hit(sense, lvl, lvl_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_prev <= 1'b1;
            pend     <= 1'b0;
        end else begin
            lvl_prev <= lvl;
            pend     <= hit | (pend & ~clr);
        end
    end

    // R5: a rising edge with rising sense must raise the flag.
    p_rise_sets_r5: assert property (@(posedge clk) disable iff (rst)
        ($rose(lvl) && !sense) |=> pend);

    // R5: a falling edge with falling sense must raise the flag.
    p_fall_sets_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(lvl) && sense) |=> pend);

    // R6: without a clear the flag holds.
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (pend && !clr) |=> pend);

    // R6: a clear with a steady input drops the flag.
    p_pend_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (clr && $stable(lvl)) |=> !pend);
endmodule

// File: rtl/sink_port_ctrl.sv
module sink_port_ctrl #(
    parameter int unsigned NUM_PINS = sink_port_pkg::SP_PINS,
    parameter int unsigned CODE_W   = sink_port_pkg::SP_CODE_W,
    parameter int unsigned DATA_W   = sink_port_pkg::SP_DATA_W,
    parameter int unsigned ADDR_W   = sink_port_pkg::SP_ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       we,
    output logic [DATA_W-1:0]          rdata,
    input  logic [NUM_PINS-1:0]        pin_in,
    output logic [NUM_PINS-1:0]        pullup_en,
    output logic [NUM_PINS-1:0]        sink_en,
    output logic [NUM_PINS*CODE_W-1:0] strength,
    output logic                       irq
);
    import sink_port_pkg::*;

    localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(REG_LEVEL);
    localparam logic [ADDR_W-1:0] A_PINS  = ADDR_W'(REG_PINS);
    localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(REG_MASK);
    localparam logic [ADDR_W-1:0] A_SENSE = ADDR_W'(REG_SENSE);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(REG_PEND);
    localparam int unsigned       CODE_BASE = int'(REG_CODE0);

    logic [NUM_PINS-1:0] level_q, mask_q, sense_q;
    logic [NUM_PINS-1:0] pend, clr_vec, pins_sync;
    logic [CODE_W-1:0]   code_q [NUM_PINS];
    logic                unmapped_wr;

    // Control registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= '1;
            mask_q  <= '0;
            sense_q <= '0;
        end else if (we) begin
            case (addr)
                A_LEVEL: level_q <= wdata[NUM_PINS-1:0];
                A_MASK:  mask_q  <= wdata[NUM_PINS-1:0];
                A_SENSE: sense_q <= wdata[NUM_PINS-1:0];
                default: ;
            endcase
        end
    end

    assign clr_vec = (we && addr == A_PEND) ? wdata[NUM_PINS-1:0] : '0;

    sink_port_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pin_in),
        .sync_out (pins_sync)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        localparam logic [ADDR_W-1:0] A_CODE = ADDR_W'(CODE_BASE + i);

        always_ff @(posedge clk) begin
            if (rst)
                code_q[i] <= '0;
            else if (we && addr == A_CODE)
                code_q[i] <= wdata[CODE_W-1:0];
        end

        assign strength[i*CODE_W +: CODE_W] = code_q[i];

        sink_port_edge u_edge (
            .clk   (clk),
            .rst   (rst),
            .lvl   (pins_sync[i]),
            .sense (sense_q[i]),
            .clr   (clr_vec[i]),
            .pend  (pend[i])
        );

        // R3: a code write shows on the pin's strength field next cycle.
        p_code_write_r3: assert property (@(posedge clk) disable iff (rst)
            (we && addr == A_CODE) |=>
                strength[i*CODE_W +: CODE_W] == $past(wdata[CODE_W-1:0]));
    end

    assign pullup_en = level_q;
    assign sink_en   = ~level_q;
    assign irq       = |(pend & mask_q);

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            A_LEVEL: rdata[NUM_PINS-1:0] = level_q;
            A_PINS:  rdata[NUM_PINS-1:0] = pins_sync;
            A_MASK:  rdata[NUM_PINS-1:0] = mask_q;
            A_SENSE: rdata[NUM_PINS-1:0] = sense_q;
            A_PEND:  rdata[NUM_PINS-1:0] = pend;
            default: ;
        endcase
        for (int j = 0; j < NUM_PINS; j++) begin
            if (addr == ADDR_W'(CODE_BASE + j))
                rdata[CODE_W-1:0] = code_q[j];
        end
    end

    assign unmapped_wr = we && addr > A_PEND && int'(addr) < CODE_BASE;

    // R2: a level write sets pull-up and sink enables on the next cycle.
    p_level_write_r2: assert property (@(posedge clk) disable iff (rst)
        (we && addr == A_LEVEL) |=>
            (pullup_en == $past(wdata[NUM_PINS-1:0]) &&
             sink_en == ~$past(wdata[NUM_PINS-1:0])));

    // R8: a write to an unused address leaves the control registers alone.
    p_unmapped_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        unmapped_wr |=> ($stable(pullup_en) && $stable(mask_q) && $stable(sense_q)));

    // R7: with no enable bit set the request stays low.
    p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);
endmodule

// File: tb/sink_port_ctrl_tb_top.sv
module sink_port_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic [7:0]  wdata;
    logic        we;
    logic [7:0]  rdata;
    logic [7:0]  pin_in;
    logic [7:0]  pullup_en;
    logic [7:0]  sink_en;
    logic [31:0] strength;
    logic        irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    sink_port_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wdata     (wdata),
        .we        (we),
        .rdata     (rdata),
        .pin_in    (pin_in),
        .pullup_en (pullup_en),
        .sink_en   (sink_en),
        .strength  (strength),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; addr = 4'd0; wdata = 8'd0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(4'd0, v); check("R1 level", v, 8'hFF);
        check("R1 pullup", pullup_en, 8'hFF);
        check("R1 sink", sink_en, 8'h00);
        check("R1 strength", strength, 32'h0);
        rd(4'd2, v); check("R1 mask", v, 8'h00);
        rd(4'd3, v); check("R1 sense", v, 8'h00);
        rd(4'd4, v); check("R1 pending", v, 8'h00);
        check("R1 irq", irq, 1'b0);
    endtask

    task automatic t_level;
        logic [7:0] v;
        wr(4'd0, 8'hA5);
        check("R2 pullup", pullup_en, 8'hA5);
        check("R2 sink", sink_en, 8'h5A);
        rd(4'd0, v); check("R8 level readback", v, 8'hA5);
        wr(4'd0, 8'h0F);
        check("R2 sink second", sink_en, 8'hF0);
    endtask

    task automatic t_strength;
        logic [31:0] exp = '0;
        logic [7:0] v;
        for (int i = 0; i < 8; i++) begin
            wr(4'(8 + i), 8'hF0 | 8'((i * 3 + 1) & 15));
            exp[i*4 +: 4] = 4'((i * 3 + 1) & 15);
        end
        check("R3 strength vector", strength, exp);
        rd(4'd9, v); check("R3 code readback", v, 8'h04);
        wr(4'd0, 8'h00);
        check("R3 strength after level change", strength, exp);
        wr(4'd0, 8'hFF);
    endtask

    task automatic t_pins;
        logic [7:0] v;
        @(negedge clk); pin_in = 8'h3C;
        @(negedge clk);
        rd(4'd1, v); check("R4 level one edge", v, 8'hFF);
        @(negedge clk);
        rd(4'd1, v); check("R4 level two edges", v, 8'h3C);
        pin_in = 8'hFF;
        settle(4);
        wr(4'd4, 8'hFF);
    endtask

    task automatic t_sense;
        logic [7:0] v;
        wr(4'd3, 8'hF0);
        wr(4'd4, 8'hFF);
        @(negedge clk); pin_in = 8'h00;
        settle(4);
        rd(4'd4, v); check("R5 falling half", v, 8'hF0);
        wr(4'd4, 8'hFF);
        @(negedge clk); pin_in = 8'hFF;
        settle(4);
        rd(4'd4, v); check("R5 rising half", v, 8'h0F);
    endtask

    task automatic t_clear;
        logic [7:0] v;
        wr(4'd4, 8'h01);
        rd(4'd4, v); check("R6 clear one", v, 8'h0E);
        wr(4'd4, 8'h00);
        rd(4'd4, v); check("R6 zero write", v, 8'h0E);
        @(negedge clk); pin_in = 8'hFE;
        settle(4);
        rd(4'd4, v); check("R5 opposite edge ignored", v, 8'h0E);
        @(negedge clk); pin_in = 8'hFF;
        @(negedge clk);
        @(negedge clk);
        addr = 4'd4; wdata = 8'h01; we = 1'b1;
        @(negedge clk);
        we = 1'b0; wdata = 8'h00;
        rd(4'd4, v); check("R6 set beats clear", v, 8'h0F);
    endtask

    task automatic t_mask;
        wr(4'd2, 8'h00);
        check("R7 all masked", irq, 1'b0);
        wr(4'd2, 8'h02);
        check("R7 enabled pending", irq, 1'b1);
        wr(4'd2, 8'h10);
        check("R7 enabled idle pin", irq, 1'b0);
        wr(4'd4, 8'hFF);
        wr(4'd2, 8'hFF);
        check("R7 nothing pending", irq, 1'b0);
    endtask

    task automatic t_unmapped;
        logic [7:0] v;
        wr(4'd0, 8'h5A);
        wr(4'd2, 8'h33);
        wr(4'd5, 8'h00);
        wr(4'd7, 8'hFF);
        rd(4'd0, v); check("R8 level untouched", v, 8'h5A);
        rd(4'd2, v); check("R8 mask untouched", v, 8'h33);
        rd(4'd5, v); check("R8 unused reads zero", v, 8'h00);
        rd(4'd3, v); check("R8 sense readback", v, 8'hF0);
    endtask

    initial begin
        rst = 1'b1; we = 1'b0; addr = '0; wdata = '0; pin_in = 8'hFF;
        settle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_level();
        t_strength();
        t_pins();
        t_sense();
        t_clear();
        t_mask();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: got timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule